// File: doc/BRIEF.md
# Multicast Hash Filter Table

This block holds a bit-vector filter for multicast destination addresses. The vector is stored as `REG_COUNT` words of 32 bits. A 48-bit address is reduced to a hash by taking a window across its last two bytes. A 2-bit filter-type input moves that window. The hash then picks one bit of the vector.

A control agent builds the filter with two commands. One clears the whole vector. The other sets the bit for a given address. Received traffic is checked through a separate lookup port, which answers in the same cycle. Software can also write or read any 32-bit word of the table directly.

`REG_COUNT` must be a power of two from 8 to 128. Within that range every window stays inside the two hashed bytes.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset every table word reads as zero and the lookup output is 0.
- R2: Address bits [47:40] are byte 0 and bits [7:0] are byte 5. With hash width HW = log2(REG_COUNT*32), the base shift is HW-8. Filter types 0, 1, 2 and 3 add 0, 1, 2 and 4 to it, giving shift s. The hash is the low HW bits of (byte4 >> (8-s)) | (byte5 << s), where byte5 is widened to 16 bits first.
- R3: The hash selects table word hash[HW-1:5] and bit hash[4:0] inside that word. A set command makes that bit read as 1 from the cycle after the command.
- R4: With REG_COUNT=128, byte4=0x34 and byte5=0x56, filter types 0, 1, 2 and 3 give hashes 0x563, 0xAC6, 0x58D and 0x634.
- R5: A lookup returns the selected bit combinationally in the cycle of the request. A set command in that same cycle is not visible to the lookup until the next cycle.
- R6: A clear command zeroes every word. A clear and a set in the same cycle leave only the newly set bit.
- R7: A set only ORs in one bit. Other bits of the word keep their values, and setting a bit that is already 1 changes nothing.
- R8: A software write replaces a whole word in the next cycle. A software read returns the addressed word combinationally.
- R9: Updates in one cycle apply in this order: clear, then software write, then set. A write and a set to the same word therefore give the written value with the set bit ORed in.
- R10: Bytes 0 to 3 of an address have no effect on which bit is set or looked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_type | input | 2 | Hash window selection, shared by set and lookup |
| cmd_clear | input | 1 | Clear the whole table |
| cmd_set | input | 1 | Set the bit for cmd_addr |
| cmd_addr | input | 48 | Address used by the set command |
| lk_addr | input | 48 | Address to look up |
| lk_hit | output | 1 | Table bit selected by lk_addr |
| sw_we | input | 1 | Software word write strobe |
| sw_widx | input | IDX_W (7) | Word index for the write |
| sw_wdata | input | 32 | Word value for the write |
| sw_ridx | input | IDX_W (7) | Word index for the read |
| sw_rdata | output | 32 | Word selected by sw_ridx |

## Verification
The bench targets each filter type using the byte pair 0x34/0x56. A mistake in the type-to-shift map or in the base shift would set a bit in the wrong word or at the wrong bit position. It also drives clear and set in the same cycle, and a write and a set to the same word in the same cycle. A wrong update order would lose either the new bit or the written value. The lookup is checked in the cycle of a concurrent set, when it must still show the old bit. Addresses that differ only in bytes 0 to 3 are used to catch a hash that draws on the wrong bytes.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 48;
    localparam int BIT_W  = 5;

    typedef enum logic [1:0] {
        FT_NARROW = 2'd0,
        FT_PLUS1  = 2'd1,
        FT_PLUS2  = 2'd2,
        FT_PLUS4  = 2'd3
    } filt_type_e;

    function automatic int extra_shift(filt_type_e t);
        case (t)
            FT_PLUS1: return 1;
            FT_PLUS2: return 2;
            FT_PLUS4: return 4;
            default:  return 0;
        endcase
    endfunction
endpackage

// File: rtl/mcf_hash.sv
module mcf_hash
    import mcf_pkg::*;
#(
    parameter int REG_COUNT = 128,
    parameter int IDX_W     = $clog2(REG_COUNT)
) (
    input  logic [1:0]        ftype,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  word_idx,
    output logic [BIT_W-1:0]  bit_idx
);
    localparam int HASH_W = IDX_W + BIT_W;
    localparam int BASE   = HASH_W - 8;

    logic [7:0]        b4, b5;
    logic [15:0]       wide;
    logic [HASH_W-1:0] hash;
    int                shift;

    always_comb begin
        b4    = addr[15:8];
        b5    = addr[7:0];
        shift = BASE + extra_shift(filt_type_e'(ftype));
        wide  = ({8'd0, b4} >> (8 - shift)) | ({8'd0, b5} << shift);
        hash  = wide[HASH_W-1:0];
        word_idx = hash[HASH_W-1:BIT_W];
        bit_idx  = hash[BIT_W-1:0];
    end
endmodule

// File: rtl/mcf_table.sv
module mcf_table
    import mcf_pkg::*;
#(
    parameter int REG_COUNT = 128,
    parameter int IDX_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [BIT_W-1:0]  set_bit,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [BIT_W-1:0]  lk_bit,
    output logic              lk_hit
);
    typedef struct packed {
        logic [REG_COUNT-1:0][WORD_W-1:0] tbl;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.tbl = '0;
        if (we)  st_d.tbl[widx] = wdata;
        if (set) st_d.tbl[set_idx][set_bit] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.tbl[ridx];
    assign lk_hit = st_q.tbl[lk_idx][lk_bit];

    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> st_q.tbl[$past(set_idx)][$past(set_bit)]);

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !we && !set) |=> (st_q.tbl == '0));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !we && !set) |=> $stable(st_q.tbl));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !set) |=> (st_q.tbl[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
    import mcf_pkg::*;
#(
    parameter int REG_COUNT = 128,
    parameter int IDX_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        filt_type,
    input  logic              cmd_clear,
    input  logic              cmd_set,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_widx,
    input  logic [WORD_W-1:0] sw_wdata,
    input  logic [IDX_W-1:0]  sw_ridx,
    output logic [WORD_W-1:0] sw_rdata
);
    logic [IDX_W-1:0] set_idx, lk_idx;
    logic [BIT_W-1:0] set_bit, lk_bit;

    mcf_hash #(.REG_COUNT(REG_COUNT), .IDX_W(IDX_W)) set_hash_i (
        .ftype(filt_type), .addr(cmd_addr), .word_idx(set_idx), .bit_idx(set_bit)
    );

    mcf_hash #(.REG_COUNT(REG_COUNT), .IDX_W(IDX_W)) lk_hash_i (
        .ftype(filt_type), .addr(lk_addr), .word_idx(lk_idx), .bit_idx(lk_bit)
    );

    mcf_table #(.REG_COUNT(REG_COUNT), .IDX_W(IDX_W)) table_i (
        .clk(clk), .rst_n(rst_n), .clr(cmd_clear), .set(cmd_set),
        .set_idx(set_idx), .set_bit(set_bit),
        .we(sw_we), .widx(sw_widx), .wdata(sw_wdata),
        .ridx(sw_ridx), .rdata(sw_rdata),
        .lk_idx(lk_idx), .lk_bit(lk_bit), .lk_hit(lk_hit)
    );

    assert_lookup_sees_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_set |=> (((lk_addr == $past(cmd_addr)) && (filt_type == $past(filt_type))) -> lk_hit));
endmodule

// File: tb/mc_hash_filter_tb.sv
`timescale 1ns/1ps
module mc_hash_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  filt_type = 2'd0;
    logic        cmd_clear = 1'b0, cmd_set = 1'b0, sw_we = 1'b0;
    logic [47:0] cmd_addr = '0, lk_addr = '0;
    logic [6:0]  sw_widx = '0, sw_ridx = '0;
    logic [31:0] sw_wdata = '0, sw_rdata;
    logic        lk_hit;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mc_hash_filter dut_i (
        .clk(clk), .rst_n(rst_n), .filt_type(filt_type),
        .cmd_clear(cmd_clear), .cmd_set(cmd_set), .cmd_addr(cmd_addr),
        .lk_addr(lk_addr), .lk_hit(lk_hit),
        .sw_we(sw_we), .sw_widx(sw_widx), .sw_wdata(sw_wdata),
        .sw_ridx(sw_ridx), .sw_rdata(sw_rdata)
    );

    function automatic int exp_hash(logic [47:0] a, int t);
        int sh = 4 + ((t == 3) ? 4 : t);
        return ((int'(a[15:8]) >> (8 - sh)) | (int'(a[7:0]) << sh)) & 'hFFF;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_word(int idx, output logic [31:0] v);
        sw_ridx = idx[6:0];
        #1 v = sw_rdata;
    endtask

    task automatic do_cycle(bit clr, bit set, logic [47:0] a, bit we, int widx, logic [31:0] wd);
        @(negedge clk);
        cmd_clear = clr; cmd_set = set; cmd_addr = a;
        sw_we = we; sw_widx = widx[6:0]; sw_wdata = wd;
        @(negedge clk);
        cmd_clear = 0; cmd_set = 0; sw_we = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 128; i += 17) begin
            read_word(i, v);
            check(v == 0, "R1 reset word", v, 0);
        end
        lk_addr = 48'h0100_5E00_3456; #1;
        check(lk_hit == 0, "R1 reset hit", lk_hit, 0);
    endtask

    task automatic t_types();
        int lit[4] = '{'h563, 'hAC6, 'h58D, 'h634};
        logic [31:0] v;
        for (int t = 0; t < 4; t++) begin
            filt_type = t[1:0];
            do_cycle(1, 0, '0, 0, 0, 0);
            do_cycle(0, 1, 48'h01AA_0012_3456, 0, 0, 0);
            check(exp_hash(48'h3456, t) == lit[t], "R2 hash formula", exp_hash(48'h3456, t), lit[t]);
            read_word(lit[t] >> 5, v);
            check(v == (32'd1 << (lit[t] & 31)), "R4/R3 type word", v, 32'd1 << (lit[t] & 31));
        end
        filt_type = 0;
    endtask

    task automatic t_same_cycle_lookup();
        do_cycle(1, 0, '0, 0, 0, 0);
        @(negedge clk);
        cmd_set = 1; cmd_addr = 48'h0000_0000_1122; lk_addr = 48'h0000_0000_1122;
        #1 check(lk_hit == 0, "R5 same-cycle lookup", lk_hit, 0);
        @(negedge clk);
        cmd_set = 0;
        #1 check(lk_hit == 1, "R5 next-cycle lookup", lk_hit, 1);
    endtask

    task automatic t_or_and_clear();
        logic [31:0] v;
        do_cycle(1, 0, '0, 0, 0, 0);
        do_cycle(0, 1, 48'h3456, 0, 0, 0);
        do_cycle(0, 1, 48'h7456, 0, 0, 0);
        read_word('h2B, v);
        check(v == 32'h88, "R7 two bits", v, 32'h88);
        do_cycle(0, 1, 48'h3456, 0, 0, 0);
        read_word('h2B, v);
        check(v == 32'h88, "R7 reset bit again", v, 32'h88);
        do_cycle(0, 1, 48'h1000, 0, 0, 0);
        read_word(0, v);
        check(v == 32'h2, "R3 word0 bit1", v, 32'h2);
        do_cycle(1, 1, 48'h3456, 0, 0, 0);
        read_word(0, v);
        check(v == 0, "R6 clear word0", v, 0);
        read_word('h2B, v);
        check(v == 32'h8, "R6 clear+set keeps new", v, 32'h8);
    endtask

    task automatic t_sw_access();
        logic [31:0] v;
        do_cycle(0, 0, '0, 1, 5, 32'hDEAD_BEEF);
        read_word(5, v);
        check(v == 32'hDEAD_BEEF, "R8 write read", v, 32'hDEAD_BEEF);
        do_cycle(0, 0, '0, 1, 5, 32'h0000_0001);
        read_word(5, v);
        check(v == 32'h1, "R8 full replace", v, 32'h1);
        do_cycle(0, 1, 48'h3456, 1, 'h2B, 32'hF000_0000);
        read_word('h2B, v);
        check(v == 32'hF000_0008, "R9 write then set", v, 32'hF000_0008);
        do_cycle(1, 0, '0, 1, 7, 32'h55);
        read_word(7, v);
        check(v == 32'h55, "R9 clear then write", v, 32'h55);
    endtask

    task automatic t_upper_bytes();
        do_cycle(1, 0, '0, 0, 0, 0);
        do_cycle(0, 1, 48'h01AA_0012_3456, 0, 0, 0);
        lk_addr = 48'hFFFF_FFFF_3456; #1;
        check(lk_hit == 1, "R10 upper bytes ignored", lk_hit, 1);
        lk_addr = 48'h01AA_0012_3457; #1;
        check(lk_hit == 0, "R10 byte5 matters", lk_hit, 0);
    endtask

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_types();
        t_same_cycle_lookup();
        t_or_and_clear();
        t_sw_access();
        t_upper_bytes();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule